// File: doc/BRIEF.md
# Bidirectional latch/register bus transceiver

This block joins an A bus and a B bus through a bank of identical, non-inverting data channels. The bank is 18 channels wide by default. Each direction (A to B, B to A) has its own storage element and its own four controls: an active-low output enable, a latch enable, a capture clock and an active-low clock enable. While a direction's latch enable is high, the storage is transparent and the far-side output follows the near-side input. While the latch enable is low, the storage takes the input only on a rising edge of that direction's capture clock, and only when its clock enable is low. At all other times it holds its value.

The block runs in one system clock domain. The capture clocks are sampled as ordinary signals, and a rising edge is recognised when one sample is low and the next is high. Each bus side is presented as a data value plus a drive flag rather than as a tri-state pin. The surrounding logic resolves the bus with these two signals. The storage has no reset, so the stored data is undefined until the first load. Only the edge-detect history is cleared.

Top module: `bidir_xcvr`

## Requirements
- R1: `b_drive` is 1 exactly while `ab_oe_n` is 0, and `a_drive` is 1 exactly while `ba_oe_n` is 0. The drive flag is the only thing the enable changes.
- R2: While a direction's latch enable is 1, its output equals its input in the same cycle. The capture clock and clock enable have no effect in that mode.
- R3: With latch enable 0 and clock enable 0, a capture-clock sample of 1 following a sample of 0 loads the input present at that system-clock edge. The output shows the loaded value from then on.
- R4: With latch enable 0, a capture clock held at 0 or held at 1 leaves the output unchanged, whatever the input does.
- R5: With latch enable 0 and clock enable 1, rising capture-clock samples leave the output unchanged.
- R6: Data is not inverted: every output bit equals the matching bit of the passed-through or stored word.
- R7: Loads take place while the output enable is 1 (drive off). The stored word stays visible on the data output and is driven unchanged once the enable returns to 0.
- R8: When latch enable goes from 1 to 0, the output keeps the input value seen at the last system-clock edge at which latch enable was still 1.
- R9: The two directions are independent: no control or data of one direction changes the output or drive flag of the other.
- R10: Reset makes the edge detector treat the capture clock as previously high. A capture clock that is already high when reset is released is therefore not an edge, and stored data is not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; capture clocks are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the edge-detect history |
| a_in | input | WIDTH | Data arriving from the A bus |
| a_out | output | WIDTH | Data presented to the A bus (B-to-A path) |
| a_drive | output | 1 | 1 while the block drives the A bus |
| b_in | input | WIDTH | Data arriving from the B bus |
| b_out | output | WIDTH | Data presented to the B bus (A-to-B path) |
| b_drive | output | 1 | 1 while the block drives the B bus |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, transparent when 1 |
| ab_cp | input | 1 | A-to-B capture clock (sampled) |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, transparent when 1 |
| ba_cp | input | 1 | B-to-A capture clock (sampled) |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |

## Verification
The closing of the transparent window and a capture-clock rise can land on the same system-clock edge. That edge must load the live input exactly once, and the next cycle must hold that value rather than take a second sample. Directed steps force this overlap, and the random phase reaches it often because latch enable and the capture clock are drawn independently every cycle. A capture that coincides with a disabled output is judged in the same way: the stored word is read from the data output while the drive flag is low. A bench model derived from the requirements gives the expected output, and data is compared only after the first load into storage. The bench never enables both directions at once and reports any cycle with both drive flags set as bus contention.

// File: rtl/bidir_xcvr.sv
`timescale 1ns/1ps
module bidir_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  input  logic             ab_oe_n,
  input  logic             ab_le,
  input  logic             ab_cp,
  input  logic             ab_ce_n,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_cp,
  input  logic             ba_ce_n
);
  localparam int NDIR = 2;

  logic [NDIR-1:0][WIDTH-1:0] src, dst;
  logic [NDIR-1:0]            le, cp, ce_n;

  assign src  = {b_in,    a_in};
  assign le   = {ba_le,   ab_le};
  assign cp   = {ba_cp,   ab_cp};
  assign ce_n = {ba_ce_n, ab_ce_n};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic             cp_q;
    logic             take;
    logic [WIDTH-1:0] store;

    always_ff @(posedge clk)
      if (!rst_n) cp_q <= 1'b1;
      else        cp_q <= cp[d];

    assign take = le[d] | (cp[d] & ~cp_q & ~ce_n[d]);

    always_ff @(posedge clk)
      if (take) store <= src[d];

    assign dst[d] = le[d] ? src[d] : store;
  end

  assign b_out   = dst[0];
  assign a_out   = dst[1];
  assign b_drive = ~ab_oe_n;
  assign a_drive = ~ba_oe_n;
endmodule

// File: rtl/bidir_xcvr_chk.sv
`timescale 1ns/1ps
module bidir_xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drive,
  input logic             ab_oe_n,
  input logic             ab_le,
  input logic             ab_cp,
  input logic             ab_ce_n,
  input logic             ba_oe_n,
  input logic             ba_le,
  input logic             ba_cp,
  input logic             ba_ce_n
);
  AST_AB_DRIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ab_oe_n) |-> b_drive); // R1
  AST_BA_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ba_oe_n) |-> !a_drive); // R1

  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !$past(ab_le) && !$past(ab_ce_n) && $past(ab_cp) && !$past(ab_cp, 2) && $past(rst_n, 2))
    |-> b_out == $past(a_in)); // R3
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !$past(ba_le) && !$past(ba_ce_n) && $past(ba_cp) && !$past(ba_cp, 2) && $past(rst_n, 2))
    |-> a_out == $past(b_in)); // R3

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !$past(ab_le) && ($past(ab_ce_n) || !$past(ab_cp) || $past(ab_cp, 2)))
    |-> b_out == $past(b_out)); // R4
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !$past(ba_le) && ($past(ba_ce_n) || !$past(ba_cp) || $past(ba_cp, 2)))
    |-> a_out == $past(a_out)); // R4

  AST_AB_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ab_le) |-> b_out == $past(a_in)); // R8
  AST_BA_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ba_le) |-> a_out == $past(b_in)); // R8
endmodule

bind bidir_xcvr bidir_xcvr_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
  .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
  .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_cp(ab_cp), .ab_ce_n(ab_ce_n),
  .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp), .ba_ce_n(ba_ce_n)
);

// File: tb/bidir_xcvr_tb_top.sv
`timescale 1ns/1ps
module bidir_xcvr_tb_top;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_drive, b_drive;
  logic         ab_oe_n = 1'b1, ab_le = 1'b0, ab_cp = 1'b0, ab_ce_n = 1'b1;
  logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0, ba_ce_n = 1'b1;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bidir_xcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_cp(ab_cp), .ab_ce_n(ab_ce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp), .ba_ce_n(ba_ce_n)
  );

  // Reference storage derived from the requirements; ok flags make the
  // comparison X-aware until the first load.
  logic [W-1:0] m_ab, m_ba;
  logic         m_ab_ok = 1'b0, m_ba_ok = 1'b0;
  logic         m_ab_cpq = 1'b1, m_ba_cpq = 1'b1;

  function automatic logic loads(logic le, logic cp, logic prev_cp, logic ce_n);
    return le || (cp && !prev_cp && !ce_n);
  endfunction

  function automatic logic [W-1:0] expect_out(logic le, logic [W-1:0] din, logic [W-1:0] st);
    return le ? din : st;
  endfunction

  always @(posedge clk) begin
    m_ab_cpq <= rst_n ? ab_cp : 1'b1;
    m_ba_cpq <= rst_n ? ba_cp : 1'b1;
    if (loads(ab_le, ab_cp, m_ab_cpq, ab_ce_n)) begin m_ab <= a_in; m_ab_ok <= 1'b1; end
    if (loads(ba_le, ba_cp, m_ba_cpq, ba_ce_n)) begin m_ba <= b_in; m_ba_ok <= 1'b1; end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic model_check();
    if (ab_le || m_ab_ok) chk("R6 b_out vs model", 32'(b_out), 32'(expect_out(ab_le, a_in, m_ab)));
    if (ba_le || m_ba_ok) chk("R6 a_out vs model", 32'(a_out), 32'(expect_out(ba_le, b_in, m_ba)));
    chk("R1 b_drive", 32'(b_drive), 32'(!ab_oe_n));
    chk("R1 a_drive", 32'(a_drive), 32'(!ba_oe_n));
    chk("R1 bus contention", 32'(a_drive && b_drive), 32'd0);
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    tick(); tick(); tick();
    #1;
    chk("R1 reset a_drive", 32'(a_drive), 32'd0);
    chk("R1 reset b_drive", 32'(b_drive), 32'd0);
    rst_n = 1'b1;
    tick();

    ab_oe_n = 1'b0; #1;
    chk("R1 enable b_drive", 32'(b_drive), 32'd1);
    chk("R9 a_drive untouched", 32'(a_drive), 32'd0);

    ab_le = 1'b1; a_in = 18'h2A5A5; #1;
    chk("R2 transparent", 32'(b_out), 32'h2A5A5);
    tick();
    ab_cp = 1'b1; ab_ce_n = 1'b0; a_in = 18'h01234; #1;
    chk("R2 follows input", 32'(b_out), 32'h01234);
    tick(); #1;
    chk("R2 clock ignored", 32'(b_out), 32'h01234);

    ab_le = 1'b0; ab_cp = 1'b0; a_in = 18'h3FFFF; #1;
    chk("R8 close keeps last", 32'(b_out), 32'h01234);
    tick(); tick(); #1;
    chk("R4 clock held low", 32'(b_out), 32'h01234);

    ab_cp = 1'b1; a_in = 18'h15555; #1;
    chk("R3 no load before edge", 32'(b_out), 32'h01234);
    tick(); #1;
    chk("R3 capture", 32'(b_out), 32'h15555);
    chk("R6 bits not inverted", 32'(~b_out), 32'(~18'h15555));

    a_in = 18'h0AAAA;
    tick(); tick(); #1;
    chk("R4 clock held high", 32'(b_out), 32'h15555);

    ab_ce_n = 1'b1; ab_cp = 1'b0; tick();
    ab_cp = 1'b1; tick(); #1;
    chk("R5 clock enable off", 32'(b_out), 32'h15555);
    ab_ce_n = 1'b0; ab_cp = 1'b0; tick();
    ab_cp = 1'b1; tick(); #1;
    chk("R3 capture after enable", 32'(b_out), 32'h0AAAA);

    ab_oe_n = 1'b1; ab_cp = 1'b0; #1;
    chk("R7 drive off", 32'(b_drive), 32'd0);
    tick();
    a_in = 18'h12345; ab_cp = 1'b1; tick(); #1;
    chk("R7 load while off", 32'(b_out), 32'h12345);
    ab_oe_n = 1'b0; #1;
    chk("R7 drive back on", 32'(b_drive), 32'd1);
    chk("R7 retained value", 32'(b_out), 32'h12345);

    ab_oe_n = 1'b1; ba_oe_n = 1'b0; ba_le = 1'b1; b_in = 18'h3C3C3; #1;
    chk("R9 B-to-A transparent", 32'(a_out), 32'h3C3C3);
    chk("R9 A-to-B untouched", 32'(b_out), 32'h12345);
    tick();
    ba_le = 1'b0; b_in = 18'h00000; tick(); #1;
    chk("R8 B-to-A close", 32'(a_out), 32'h3C3C3);
    chk("R9 A-to-B still held", 32'(b_out), 32'h12345);

    ab_cp = 1'b1; rst_n = 1'b0; tick(); tick();
    rst_n = 1'b1; a_in = 18'h00F0F; tick(); tick(); #1;
    chk("R10 high clock at release", 32'(b_out), 32'h12345);
    chk("R10 storage kept over reset", 32'(a_out), 32'h3C3C3);
    ab_cp = 1'b0; tick();
    ab_cp = 1'b1; tick(); #1;
    chk("R10 first real edge", 32'(b_out), 32'h00F0F);

    // Same-edge overlap: latch closes while the capture clock rises.
    ab_le = 1'b1; ab_cp = 1'b0; a_in = 18'h2F00F; tick();
    ab_le = 1'b0; ab_cp = 1'b1; a_in = 18'h10FF0; #1;
    chk("R8 close before rising edge", 32'(b_out), 32'h2F00F);
    tick(); #1;
    chk("R3 edge right after close", 32'(b_out), 32'h10FF0);

    for (int i = 0; i < 3000; i++) begin
      int sel;
      tick();
      sel     = int'($urandom % 3);
      ab_oe_n = (sel != 0);
      ba_oe_n = (sel != 1);
      ab_le   = ($urandom % 4) == 0;
      ba_le   = ($urandom % 4) == 0;
      ab_cp   = $urandom % 2;
      ba_cp   = $urandom % 2;
      ab_ce_n = ($urandom % 4) == 0;
      ba_ce_n = ($urandom % 4) == 0;
      a_in    = W'($urandom);
      b_in    = W'($urandom);
      if ((i % 500) == 250) begin
        rst_n = 1'b0;
      end else begin
        rst_n = 1'b1;
      end
      #1;
      model_check();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule